// File: doc/BRIEF.md
# Quaternary-Tree Carry-Select Adder

This block adds two 64-bit operands and a carry-in, and returns the 64-bit sum and the carry-out. It is purely combinational, so the result follows the inputs within the same cycle. It is meant to sit in an execution datapath where the adder is on the critical path.

The carry work is split into two parts. The first part is a sparse carry tree that resolves only the carries at 16-bit boundaries. The second part is a set of side paths that work in parallel with that tree. In the first stage, each nibble is reduced to a group propagate and a group generate. From these values, the sparse tree forms the carries into bits 16, 32 and 48. The adder carry-in serves as the carry into bit 0.

Alongside the tree, an intermediate carry generator ripples through the nibbles of each 16-bit group twice, once assuming an incoming carry of 0 and once assuming 1. The resolved 16-bit carry then picks between the two results at every nibble boundary of its group. A second side path computes two sums for every nibble, one for each value of the nibble's incoming carry. The selected nibble carry chooses between them. The carry-out is the selected carry leaving the top 16-bit group.

Top module: `qt_adder`

## Requirements
- R1: `sumOut` equals the low 64 bits of `opA + opB + carryIn` for every input combination.
- R2: `carryOut` equals bit 64 of the 65-bit value `opA + opB + carryIn`.
- R3: A carry produced below a 16-bit boundary reaches bit 16, 32 or 48 through the sparse tree. For example, `opA` with ones in bits 0 to 16k-1 plus `opB = 1` gives a sum of exactly 2^(16k).
- R4: A carry produced below a nibble boundary inside a 16-bit group reaches that boundary through the conditional-carry selection. For example, `opA` with ones in bits 0 to 4j-1 plus `carryIn = 1` gives a sum of exactly 2^(4j).
- R5: When every bit propagates (`opA == ~opB`) and `carryIn = 1`, `sumOut` is 0 and `carryOut` is 1. With `carryIn = 0`, `sumOut` is all ones and `carryOut` is 0.
- R6: When `opA` and `opB` share no set bit and `carryIn = 0`, `sumOut` equals `opA | opB` and `carryOut` is 0.
- R7: The outputs depend only on the current inputs. A new input pattern is fully reflected at the outputs in the same cycle, with no dependence on earlier patterns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 64 | First addend |
| opB | input | 64 | Second addend |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | 64 | Low 64 bits of the sum |
| carryOut | output | 1 | Carry out of bit 63 |

## Verification
The hardest case to reach is a carry that is born in one nibble or group and has to travel through many fully propagating nibbles before it lands. Under random operands, such long runs almost never occur. The bench therefore builds runs of ones of every length that ends on a nibble boundary. It starts each run with either `carryIn` or a one in `opB`, so that every intermediate selection and every sparse-tree carry is exercised on its own. It then runs the all-propagate case with both carry-in values, and follows with pseudo-random operands that are compared against a behavioural sum.

// File: rtl/qt_adder_pkg.sv
package qt_adder_pkg;
  localparam int unsigned NIB_W = 4;

  typedef struct packed {
    logic prop;
    logic gen;
  } pgPair_t;
endpackage

// File: rtl/qt_pg_stage.sv
module qt_pg_stage
  import qt_adder_pkg::*;
#(
  parameter int unsigned WIDTH = 64
) (
  input  logic [WIDTH-1:0]                 opA,
  input  logic [WIDTH-1:0]                 opB,
  output pgPair_t [WIDTH/NIB_W-1:0]        nibPg
);
  localparam int unsigned NUM_NIB = WIDTH / NIB_W;

  for (genvar n = 0; n < NUM_NIB; n++) begin : gNib
    logic [NIB_W-1:0] bitP;
    logic [NIB_W-1:0] bitG;
    assign bitP = opA[n*NIB_W +: NIB_W] ^ opB[n*NIB_W +: NIB_W];
    assign bitG = opA[n*NIB_W +: NIB_W] & opB[n*NIB_W +: NIB_W];

    always_comb begin
      logic runG;
      runG = 1'b0;
      for (int i = 0; i < NIB_W; i++) begin
        runG = bitG[i] | (bitP[i] & runG);
      end
      nibPg[n].gen  = runG;
      nibPg[n].prop = &bitP;
    end
  end
endmodule

// File: rtl/qt_sparse_tree.sv
module qt_sparse_tree
  import qt_adder_pkg::*;
#(
  parameter int unsigned NUM_GRP     = 4,
  parameter int unsigned NIB_PER_GRP = 4
) (
  input  pgPair_t [(NUM_GRP-1)*NIB_PER_GRP-1:0] lowPg,
  input  logic                                  carryIn,
  output logic    [NUM_GRP-1:0]                 critCarry
);
  logic [NUM_GRP-2:0] grpP;
  logic [NUM_GRP-2:0] grpG;

  for (genvar k = 0; k < NUM_GRP - 1; k++) begin : gGrp
    always_comb begin
      logic accP;
      logic accG;
      accP = 1'b1;
      accG = 1'b0;
      for (int j = 0; j < NIB_PER_GRP; j++) begin
        accG = lowPg[k*NIB_PER_GRP+j].gen | (lowPg[k*NIB_PER_GRP+j].prop & accG);
        accP = accP & lowPg[k*NIB_PER_GRP+j].prop;
      end
      grpP[k] = accP;
      grpG[k] = accG;
    end
  end

  assign critCarry[0] = carryIn;
  for (genvar k = 1; k < NUM_GRP; k++) begin : gCrit
    assign critCarry[k] = grpG[k-1] | (grpP[k-1] & critCarry[k-1]);
  end
endmodule

// File: rtl/qt_cond_carry.sv
module qt_cond_carry
  import qt_adder_pkg::*;
#(
  parameter int unsigned NUM_GRP     = 4,
  parameter int unsigned NIB_PER_GRP = 4
) (
  input  pgPair_t [NUM_GRP*NIB_PER_GRP-1:0] nibPg,
  input  logic    [NUM_GRP-1:0]             critCarry,
  output logic    [NUM_GRP*NIB_PER_GRP-1:0] nibCarry,
  output logic                              carryOut
);
  for (genvar k = 0; k < NUM_GRP; k++) begin : gGrp
    logic [NIB_PER_GRP:0] cond0;
    logic [NIB_PER_GRP:0] cond1;
    assign cond0[0] = 1'b0;
    assign cond1[0] = 1'b1;

    for (genvar j = 0; j < NIB_PER_GRP; j++) begin : gRip
      assign cond0[j+1] = nibPg[k*NIB_PER_GRP+j].gen | (nibPg[k*NIB_PER_GRP+j].prop & cond0[j]);
      assign cond1[j+1] = nibPg[k*NIB_PER_GRP+j].gen | (nibPg[k*NIB_PER_GRP+j].prop & cond1[j]);
    end

    assign nibCarry[k*NIB_PER_GRP] = critCarry[k];
    for (genvar j = 1; j < NIB_PER_GRP; j++) begin : gSel
      assign nibCarry[k*NIB_PER_GRP+j] = critCarry[k] ? cond1[j] : cond0[j];
    end

    if (k == NUM_GRP - 1) begin : gTop
      assign carryOut = critCarry[k] ? cond1[NIB_PER_GRP] : cond0[NIB_PER_GRP];
    end
  end
endmodule

// File: rtl/qt_cond_sum.sv
module qt_cond_sum
  import qt_adder_pkg::*;
(
  input  logic [NIB_W-1:0] nibA,
  input  logic [NIB_W-1:0] nibB,
  input  logic             nibCin,
  output logic [NIB_W-1:0] nibSum
);
  logic [NIB_W-1:0] sumIf0;
  logic [NIB_W-1:0] sumIf1;

  always_comb begin
    logic rc0;
    logic rc1;
    rc0 = 1'b0;
    rc1 = 1'b1;
    for (int i = 0; i < NIB_W; i++) begin
      sumIf0[i] = nibA[i] ^ nibB[i] ^ rc0;
      sumIf1[i] = nibA[i] ^ nibB[i] ^ rc1;
      rc0 = (nibA[i] & nibB[i]) | ((nibA[i] ^ nibB[i]) & rc0);
      rc1 = (nibA[i] & nibB[i]) | ((nibA[i] ^ nibB[i]) & rc1);
    end
  end

  assign nibSum = nibCin ? sumIf1 : sumIf0;
endmodule

// File: rtl/qt_adder.sv
module qt_adder
  import qt_adder_pkg::*;
#(
  parameter int unsigned WIDTH = 64,
  parameter int unsigned GRP_W = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);
  localparam int unsigned NUM_NIB     = WIDTH / NIB_W;
  localparam int unsigned NUM_GRP     = WIDTH / GRP_W;
  localparam int unsigned NIB_PER_GRP = GRP_W / NIB_W;
  localparam int unsigned LOW_NIB     = (NUM_GRP - 1) * NIB_PER_GRP;

  pgPair_t [NUM_NIB-1:0] nibPg;
  logic    [NUM_GRP-1:0] critCarry;
  logic    [NUM_NIB-1:0] nibCarry;

  qt_pg_stage #(.WIDTH(WIDTH)) pg_i (
    .opA   (opA),
    .opB   (opB),
    .nibPg (nibPg)
  );

  qt_sparse_tree #(.NUM_GRP(NUM_GRP), .NIB_PER_GRP(NIB_PER_GRP)) tree_i (
    .lowPg     (nibPg[LOW_NIB-1:0]),
    .carryIn   (carryIn),
    .critCarry (critCarry)
  );

  qt_cond_carry #(.NUM_GRP(NUM_GRP), .NIB_PER_GRP(NIB_PER_GRP)) icg_i (
    .nibPg     (nibPg),
    .critCarry (critCarry),
    .nibCarry  (nibCarry),
    .carryOut  (carryOut)
  );

  for (genvar n = 0; n < NUM_NIB; n++) begin : gSum
    qt_cond_sum sum_i (
      .nibA   (opA[n*NIB_W +: NIB_W]),
      .nibB   (opB[n*NIB_W +: NIB_W]),
      .nibCin (nibCarry[n]),
      .nibSum (sumOut[n*NIB_W +: NIB_W])
    );
  end
endmodule

// File: rtl/qt_adder_chk.sv
module qt_adder_chk #(
  parameter int unsigned WIDTH = 64
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             carryIn,
  input logic [WIDTH-1:0] sumOut,
  input logic             carryOut
);
  logic [WIDTH:0] refFull;
  assign refFull = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn};

  always_comb begin
    AST_SUM_VALUE: assert (sumOut == refFull[WIDTH-1:0]); // R1
    AST_CARRY_OUT: assert (carryOut == refFull[WIDTH]); // R2
    AST_FULL_PROP: assert (!((opA == ~opB) && carryIn) || ((sumOut == '0) && carryOut)); // R5
    AST_DISJOINT_OR: assert (!(((opA & opB) == '0) && !carryIn) || ((sumOut == (opA | opB)) && !carryOut)); // R6
    AST_GROUP_CROSS: assert (!((opA[15:0] == 16'hFFFF) && (opB[15:0] == 16'h0001) && (opA[WIDTH-1:16] == '0) && (opB[WIDTH-1:16] == '0) && !carryIn) || (sumOut == {{(WIDTH-17){1'b0}}, 17'h10000})); // R3
  end
endmodule

bind qt_adder qt_adder_chk #(.WIDTH(WIDTH)) chk_i (
  .opA      (opA),
  .opB      (opB),
  .carryIn  (carryIn),
  .sumOut   (sumOut),
  .carryOut (carryOut)
);

// File: tb/qt_adder_tb_top.sv
module qt_adder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic        carryIn = 1'b0;
  logic [63:0] sumOut;
  logic        carryOut;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  qt_adder dut_i (
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .sumOut   (sumOut),
    .carryOut (carryOut)
  );

  task automatic apply(input string req, input logic [63:0] a, input logic [63:0] b, input logic c);
    logic [64:0] expFull;
    @(posedge clk);
    #1;
    opA = a;
    opB = b;
    carryIn = c;
    expFull = 65'(a) + 65'(b) + 65'(c);
    @(negedge clk);
    checks++;
    if ({carryOut, sumOut} !== expFull) begin
      errors++;
      $display("FAIL %s: a=%h b=%h cin=%0d actual=%0h_%h expected=%0h_%h",
               req, a, b, c, carryOut, sumOut, expFull[64], expFull[63:0]);
    end
  endtask

  task automatic expectExact(input string req, input logic [63:0] s, input logic co);
    checks++;
    if (sumOut !== s || carryOut !== co) begin
      errors++;
      $display("FAIL %s: actual=%0h_%h expected=%0h_%h", req, carryOut, sumOut, co, s);
    end
  endtask

  initial begin
    logic [63:0] lfsrA;
    logic [63:0] lfsrB;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    @(negedge clk);
    // reset state: all-zero inputs give zero outputs (R1, R6)
    expectExact("R1_reset", 64'h0, 1'b0);

    // nibble and group boundary crossings
    for (int j = 1; j < 16; j++) begin
      logic [63:0] ones;
      ones = (64'h1 << (4 * j)) - 64'h1;
      if (j % 4 == 0) begin
        apply("R3_opB", ones, 64'h1, 1'b0);
        expectExact("R3_exact", 64'h1 << (4 * j), 1'b0);
        apply("R3_cin", ones, 64'h0, 1'b1);
      end else begin
        apply("R4_opB", ones, 64'h1, 1'b0);
        expectExact("R4_exact", 64'h1 << (4 * j), 1'b0);
        apply("R4_cin", ones, 64'h0, 1'b1);
        expectExact("R4_cin_exact", 64'h1 << (4 * j), 1'b0);
      end
    end

    // carry generated mid-group runs into the next group
    apply("R3_mid", 64'h0000_0000_FFFF_FF00, 64'h0000_0000_0000_0100, 1'b0);
    apply("R3_top", 64'h0FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 1'b0);

    // full propagate
    apply("R5_cin1", 64'hA5A5_5A5A_0F0F_F0F0, ~64'hA5A5_5A5A_0F0F_F0F0, 1'b1);
    expectExact("R5_cin1_exact", 64'h0, 1'b1);
    apply("R5_cin0", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0);
    expectExact("R5_cin0_exact", 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);

    // carry-out cases
    apply("R2_max", 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    expectExact("R2_max_exact", 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    apply("R2_msb", 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0);
    expectExact("R2_msb_exact", 64'h0, 1'b1);

    // disjoint operands
    apply("R6_dis", 64'hF0F0_F0F0_F0F0_F0F0, 64'h0F0F_0F0F_0F0F_0F0F, 1'b0);
    expectExact("R6_dis_exact", 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    apply("R6_sparse", 64'h1248_0000_8421_0000, 64'h0000_1248_0000_8421, 1'b0);

    // history independence: same pattern after different predecessors (R7)
    apply("R7_prev", 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b1);
    apply("R7_after", 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 1'b0);
    apply("R7_prev2", 64'h0, 64'h0, 1'b0);
    apply("R7_after2", 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 1'b0);

    // pseudo-random operands
    lfsrA = 64'hACE1_2468_1357_BDF0;
    lfsrB = 64'h0F1E_2D3C_4B5A_6978;
    for (int i = 0; i < 300; i++) begin
      lfsrA = {lfsrA[62:0], lfsrA[63] ^ lfsrA[62] ^ lfsrA[60] ^ lfsrA[59]};
      lfsrB = {lfsrB[62:0], lfsrB[63] ^ lfsrB[62] ^ lfsrB[60] ^ lfsrB[59]};
      apply("R1_rand", lfsrA, (i % 3 == 0) ? ~lfsrA ^ (64'h1 << (i % 64)) : lfsrB, i[0]);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule